// File: doc/BRIEF.md
# Core and Auxiliary Up/Down Timer Group

This block holds three 16-bit up/down timers: one core timer and two auxiliary timers, called A and B. Each timer works in one of several modes. It can count a prescaled copy of the system clock, count that clock only while its gate pin is at a chosen level, or count edges on its own input pin. An auxiliary timer can also stop counting and act for the core timer. It then either captures the core count or loads its own value into the core timer.

The core timer drives a toggle latch. The latch flips on every core overflow or underflow and is visible on an output pin. Each edge of the latch can trigger a reload from an auxiliary timer. If timer A reloads on the latch's rising edge and timer B reloads on its falling edge, the core timer produces a continuous PWM wave with no software involvement. A sets the length of the high phase and B sets the length of the low phase. Latch edges can also clock an auxiliary timer, which chains two timers into one longer count.

Software uses a small register port with a write strobe and a combinational read. All pin inputs are assumed to be synchronised to the clock already.

Top module: `timer_trio`

## Requirements
- R1: After reset, all three counts, all three control words, the status register (address 6) and the outputs `tl_out` and `irq` read zero.
- R2: A register write to a count (address 0 core, 1 A, 2 B) is loaded in that cycle and overrides any count step, capture or reload in the same cycle.
- R3: Mode 0 (control bits [5:3] = 0), with run set (bit 6), steps the count once every 8·2^sel system clocks, where sel is control bits [2:0]. With run clear, the count holds.
- R4: Mode 2 steps on prescaled ticks only while the timer's pin is low. Mode 3 steps on prescaled ticks only while the pin is high.
- R5: Mode 1 steps once per selected pin edge. Sel bit 0 enables rising edges and sel bit 1 enables falling edges. An edge is found by comparing the current pin sample with the sample from the previous cycle.
- R6: Control bit 7 set means count down. When control bit 8 is set and the timer's up/down pin is high, the direction is inverted.
- R7: An up step from FFFF to 0000 or a down step from 0000 to FFFF sets a sticky flag: status bit 0 for the core, bit 1 for A, bit 2 for B. The flags drive `irq`. Writing a 1 to a status bit clears that flag.
- R8: The core toggle latch flips on every core wrap. It drives `tl_out` and reads back as status bit 3.
- R9: An auxiliary timer in mode 5 does not count. On its trigger it copies the core count.
- R10: An auxiliary timer in mode 4 does not count. On its trigger it loads its own value into the core timer. The trigger is the pin edges chosen by sel[1:0] when sel bit 2 is 0, or the latch rising (sel bit 0) and falling (sel bit 1) transitions when sel bit 2 is 1. If A and B trigger in the same cycle, A wins.
- R11: With A reloading on the latch rising transition and B on the falling transition, the core timer in mode 0 keeps `tl_out` high for (2^16 − A) ticks and low for (2^16 − B) ticks, period after period.
- R12: An auxiliary timer in mode 1 with sel bit 2 set counts the core latch transitions chosen by sel[1:0], so it extends the core count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tin | input | 3 | Count/gate/trigger pin per timer (bit 0 core, 1 A, 2 B) |
| tud | input | 3 | External up/down pin per timer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0–2 counts, 3–5 controls, 6 status |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address, same map as writes |
| rd_data | output | 16 | Combinational read data |
| tl_out | output | 1 | Core toggle latch |
| irq | output | 3 | Sticky wrap flags (core, A, B) |

## Verification
Counter mode is driven with single pin pulses under the rising, falling, both and none edge selections. This shows whether each edge class is counted on its own. Prescaled and gated counts are measured over 64-cycle windows, and such a window holds a fixed number of ticks at any phase. This separates a wrong divider from a wrong gate polarity. Wraps are forced by writing FFFF or 0000 next to a pulse, in each direction and with the direction pin set both ways. PWM is judged by the lengths of successive high and low runs of `tl_out`, so a swapped or missing reload changes a run length, and a run of four latch flips checks the chained count.

// File: rtl/tgrp_pkg.sv
package tgrp_pkg;
    localparam int PS_BITS = 3;

    typedef enum logic [2:0] {
        MD_TIMER   = 3'd0,
        MD_COUNT   = 3'd1,
        MD_GATE_LO = 3'd2,
        MD_GATE_HI = 3'd3,
        MD_RELOAD  = 3'd4,
        MD_CAPTURE = 3'd5,
        MD_RSV6    = 3'd6,
        MD_RSV7    = 3'd7
    } mode_e;

    typedef struct packed {
        logic [6:0]         rsvd;
        logic               ext_dir;
        logic               down;
        logic               run;
        mode_e              mode;
        logic [PS_BITS-1:0] sel;
    } ctl_t;

    function automatic logic pick_edge(input logic [1:0] s, input logic r, input logic f);
        return (s[0] & r) | (s[1] & f);
    endfunction
endpackage

// File: rtl/tgrp_prescale.sv
module tgrp_prescale #(
    parameter int BASE_SH = 3,
    parameter int NTICK   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [NTICK-1:0] tick_v
);
    localparam int PRE_W = BASE_SH + NTICK - 1;

    logic [PRE_W-1:0] pre;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre <= '0;
        else        pre <= pre + 1'b1;
    end

    for (genvar g = 0; g < NTICK; g++) begin : g_tick
        assign tick_v[g] = &pre[BASE_SH+g-1:0];
    end
endmodule

// File: rtl/tgrp_edge.sv
module tgrp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= sig;
    end

    assign rise = sig & ~prev;
    assign fall = ~sig & prev;
endmodule

// File: rtl/tgrp_core.sv
module tgrp_core
    import tgrp_pkg::*;
#(
    parameter int TW    = 16,
    parameter int NTICK = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_t             ctl,
    input  logic [NTICK-1:0] tick_v,
    input  logic             pin_lvl,
    input  logic             pin_rise,
    input  logic             pin_fall,
    input  logic             ud_pin,
    input  logic             wr_cnt,
    input  logic [TW-1:0]    wr_data,
    input  logic             reload_req,
    input  logic [TW-1:0]    reload_val,
    output logic [TW-1:0]    cnt,
    output logic             wrap,
    output logic             tl,
    output logic             tl_rise_ev,
    output logic             tl_fall_ev
);
    logic          tick, step, adv, go_down;
    logic [TW-1:0] nxt;
    logic [6:0]    unused_rsvd;

    assign unused_rsvd = ctl.rsvd;
    assign tick    = tick_v[ctl.sel];
    assign go_down = ctl.down ^ (ctl.ext_dir & ud_pin);

    always_comb begin
        unique case (ctl.mode)
            MD_TIMER:   step = ctl.run & tick;
            MD_COUNT:   step = ctl.run & pick_edge(ctl.sel[1:0], pin_rise, pin_fall);
            MD_GATE_LO: step = ctl.run & tick & ~pin_lvl;
            MD_GATE_HI: step = ctl.run & tick & pin_lvl;
            default:    step = 1'b0;
        endcase
    end

    assign adv        = step & ~wr_cnt;
    assign nxt        = go_down ? cnt - 1'b1 : cnt + 1'b1;
    assign wrap       = adv & (go_down ? (cnt == '0) : (&cnt));
    assign tl_rise_ev = wrap & ~tl;
    assign tl_fall_ev = wrap & tl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            tl  <= 1'b0;
        end else begin
            if (wr_cnt)          cnt <= wr_data;
            else if (reload_req) cnt <= reload_val;
            else if (adv)        cnt <= nxt;
            tl <= tl ^ wrap;
        end
    end

    a_r2_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> cnt == $past(wr_data));
    a_r8_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(tl));
    a_r8_latch_flips: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> tl != $past(tl));
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.run && !wr_cnt && !reload_req) |=> $stable(cnt));
endmodule

// File: rtl/tgrp_aux.sv
module tgrp_aux
    import tgrp_pkg::*;
#(
    parameter int TW    = 16,
    parameter int NTICK = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_t             ctl,
    input  logic [NTICK-1:0] tick_v,
    input  logic             pin_lvl,
    input  logic             pin_rise,
    input  logic             pin_fall,
    input  logic             ud_pin,
    input  logic             tl_rise_ev,
    input  logic             tl_fall_ev,
    input  logic [TW-1:0]    core_cnt,
    input  logic             wr_cnt,
    input  logic [TW-1:0]    wr_data,
    output logic [TW-1:0]    cnt,
    output logic             wrap,
    output logic             reload_req
);
    logic          tick, trig, step, cap, adv, go_down;
    logic [TW-1:0] nxt;
    logic [6:0]    unused_rsvd;

    assign unused_rsvd = ctl.rsvd;
    assign tick    = tick_v[ctl.sel];
    assign go_down = ctl.down ^ (ctl.ext_dir & ud_pin);
    assign trig    = ctl.sel[2] ? pick_edge(ctl.sel[1:0], tl_rise_ev, tl_fall_ev)
                                : pick_edge(ctl.sel[1:0], pin_rise, pin_fall);

    always_comb begin
        step       = 1'b0;
        reload_req = 1'b0;
        cap        = 1'b0;
        unique case (ctl.mode)
            MD_TIMER:   step = ctl.run & tick;
            MD_COUNT:   step = ctl.run & trig;
            MD_GATE_LO: step = ctl.run & tick & ~pin_lvl;
            MD_GATE_HI: step = ctl.run & tick & pin_lvl;
            MD_RELOAD:  reload_req = trig;
            MD_CAPTURE: cap = trig;
            default:    step = 1'b0;
        endcase
    end

    assign adv  = step & ~wr_cnt;
    assign nxt  = go_down ? cnt - 1'b1 : cnt + 1'b1;
    assign wrap = adv & (go_down ? (cnt == '0) : (&cnt));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (wr_cnt)     cnt <= wr_data;
        else if (cap)        cnt <= core_cnt;
        else if (adv)        cnt <= nxt;
    end

    a_r9_capture_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.mode == MD_CAPTURE && trig && !wr_cnt) |=> cnt == $past(core_cnt));
    a_r10_reload_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.mode == MD_RELOAD && !wr_cnt) |=> $stable(cnt));
endmodule

// File: rtl/timer_trio.sv
module timer_trio
    import tgrp_pkg::*;
#(
    parameter int TW      = 16,
    parameter int BASE_SH = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    tin,
    input  logic [2:0]    tud,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [TW-1:0] wr_data,
    input  logic [2:0]    rd_addr,
    output logic [TW-1:0] rd_data,
    output logic          tl_out,
    output logic [2:0]    irq
);
    localparam int NTICK = 1 << PS_BITS;
    localparam int NTMR  = 3;

    logic [NTICK-1:0] tick_v;
    logic [NTMR-1:0]  rise_v, fall_v, wr_cnt, wr_ctl, wrap_v, rq_v;
    logic [TW-1:0]    cnt [NTMR];
    ctl_t             ctl_q [NTMR];
    logic [NTMR-1:0]  flags_q;
    logic             wr_flg, tl, tl_rise_ev, tl_fall_ev, core_rq;
    logic [TW-1:0]    core_rv;

    tgrp_prescale #(.BASE_SH(BASE_SH), .NTICK(NTICK)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_v(tick_v));

    for (genvar i = 0; i < NTMR; i++) begin : g_tmr
        tgrp_edge u_edge (.clk(clk), .rst_n(rst_n), .sig(tin[i]),
                          .rise(rise_v[i]), .fall(fall_v[i]));
        assign wr_cnt[i] = wr_en && (wr_addr == 3'(i));
        assign wr_ctl[i] = wr_en && (wr_addr == 3'(NTMR + i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         ctl_q[i] <= '0;
            else if (wr_ctl[i]) ctl_q[i] <= ctl_t'(wr_data[15:0]);
        end
    end

    assign wr_flg = wr_en && (wr_addr == 3'd6);

    // R10: auxiliary A has priority over B when both request a reload
    assign core_rq = rq_v[1] | rq_v[2];
    assign core_rv = rq_v[1] ? cnt[1] : cnt[2];
    assign rq_v[0] = 1'b0;

    tgrp_core #(.TW(TW), .NTICK(NTICK)) u_core (
        .clk(clk), .rst_n(rst_n), .ctl(ctl_q[0]), .tick_v(tick_v),
        .pin_lvl(tin[0]), .pin_rise(rise_v[0]), .pin_fall(fall_v[0]), .ud_pin(tud[0]),
        .wr_cnt(wr_cnt[0]), .wr_data(wr_data), .reload_req(core_rq), .reload_val(core_rv),
        .cnt(cnt[0]), .wrap(wrap_v[0]), .tl(tl), .tl_rise_ev(tl_rise_ev), .tl_fall_ev(tl_fall_ev));

    for (genvar j = 1; j < NTMR; j++) begin : g_aux
        tgrp_aux #(.TW(TW), .NTICK(NTICK)) u_aux (
            .clk(clk), .rst_n(rst_n), .ctl(ctl_q[j]), .tick_v(tick_v),
            .pin_lvl(tin[j]), .pin_rise(rise_v[j]), .pin_fall(fall_v[j]), .ud_pin(tud[j]),
            .tl_rise_ev(tl_rise_ev), .tl_fall_ev(tl_fall_ev), .core_cnt(cnt[0]),
            .wr_cnt(wr_cnt[j]), .wr_data(wr_data),
            .cnt(cnt[j]), .wrap(wrap_v[j]), .reload_req(rq_v[j]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~(wr_flg ? wr_data[NTMR-1:0] : '0)) | wrap_v;
    end

    always_comb begin
        unique case (rd_addr)
            3'd0, 3'd1, 3'd2: rd_data = cnt[rd_addr];
            3'd3:    rd_data = TW'(ctl_q[0]);
            3'd4:    rd_data = TW'(ctl_q[1]);
            3'd5:    rd_data = TW'(ctl_q[2]);
            3'd6:    rd_data = {{(TW-NTMR-1){1'b0}}, tl, flags_q};
            default: rd_data = '0;
        endcase
    end

    assign tl_out = tl;
    assign irq    = flags_q;

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[0] && !(wr_flg && wr_data[0])) |=> flags_q[0]);
    a_r7_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_v[0] |=> flags_q[0]);
endmodule

// File: tb/timer_trio_test.sv
module timer_trio_test;
    timeunit 1ns;
    timeprecision 100ps;

    typedef struct {
        int          addr;
        logic [15:0] exp;
        int          kind;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  tin = '0, tud = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        tl_out;
    logic [2:0]  irq;

    int n_chk = 0, n_fail = 0, pushed = 0, served = 0;
    bit done = 0;
    item_t q[$];

    timer_trio uut (.clk(clk), .rst_n(rst_n), .tin(tin), .tud(tud), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tl_out(tl_out), .irq(irq));

    always #2.5 clk = ~clk;

    // monitor: pops expected items and compares against the ports
    initial begin
        item_t it;
        logic [15:0] act, base_v;
        base_v = '0;
        forever begin
            wait (q.size() != 0);
            it = q.pop_front();
            if (it.addr == 8) begin
                #0.1;
                act = {12'b0, tl_out, irq};
            end else begin
                rd_addr = it.addr[2:0];
                #0.1;
                act = rd_data;
            end
            if (it.kind == 1) base_v = act;
            else begin
                logic [15:0] e;
                e = (it.kind == 2) ? base_v + it.exp : it.exp;
                n_chk++;
                if (act !== e) begin
                    n_fail++;
                    $display("FAIL %s addr %0d: actual %h expected %h", it.tag, it.addr, act, e);
                end
            end
            served++;
        end
    end

    task automatic push(input int a, input logic [15:0] e, input int k, input string t);
        item_t it;
        it.addr = a; it.exp = e; it.kind = k; it.tag = t;
        pushed++;
        q.push_back(it);
        wait (served == pushed);
    endtask

    task automatic chk(input int a, input logic [15:0] e, input string t);
        push(a, e, 0, t);
    endtask

    task automatic chk_val(input int act, input int e, input string t);
        n_chk++;
        if (act != e) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", t, act, e);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int i);
        @(negedge clk); tin[i] = 1'b1;
        @(negedge clk); tin[i] = 1'b0;
        @(negedge clk);
    endtask

    task automatic window(input int a, input logic [15:0] d, input string t);
        push(a, '0, 1, t);
        repeat (64) @(negedge clk);
        push(a, d, 2, t);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic tl0;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 7; a++) chk(a, 16'h0, "R1 reset");
        chk(8, 16'h0, "R1 pins");

        // R5 counter mode edge selection on core
        wr(3, 16'd73);
        repeat (3) pulse(0);
        chk(0, 16'd3, "R5 rising");
        wr(3, 16'd74);
        repeat (2) pulse(0);
        chk(0, 16'd5, "R5 falling");
        wr(3, 16'd75);
        pulse(0);
        chk(0, 16'd7, "R5 both");
        wr(3, 16'd72);
        pulse(0);
        chk(0, 16'd7, "R5 none");

        // R2 write beats counting in the same cycle
        wr(3, 16'd73);
        @(negedge clk);
        tin[0] = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'h1234;
        @(negedge clk);
        wr_en = 1'b0; tin[0] = 1'b0;
        @(negedge clk);
        chk(0, 16'h1234, "R2 write priority");

        // R6 direction
        wr(3, 16'd201);
        wr(0, 16'd5);
        pulse(0);
        chk(0, 16'd4, "R6 down");
        tud[0] = 1'b1;
        wr(3, 16'd457);
        pulse(0);
        chk(0, 16'd5, "R6 pin inverts");
        tud[0] = 1'b0;
        pulse(0);
        chk(0, 16'd4, "R6 pin low");

        // R7 / R8 wraps
        wr(3, 16'd73);
        wr(0, 16'hFFFF);
        pulse(0);
        chk(0, 16'h0000, "R7 overflow");
        chk(6, 16'h0009, "R8 latch and R7 flag");
        chk(8, 16'h0009, "R8 tl_out and R7 irq");
        wr(3, 16'd201);
        pulse(0);
        chk(0, 16'hFFFF, "R7 underflow");
        chk(6, 16'h0001, "R8 latch back, R7 sticky");
        wr(6, 16'h0001);
        chk(6, 16'h0000, "R7 clear");

        // R3 prescaled timer
        wr(0, 16'h0);
        wr(3, 16'd64);
        window(0, 16'd8, "R3 sel0");
        wr(3, 16'd66);
        window(0, 16'd2, "R3 sel2");
        wr(3, 16'd2);
        window(0, 16'd0, "R3 run clear");

        // R4 gated
        wr(3, 16'd88);
        window(0, 16'd0, "R4 gate high, pin low");
        @(negedge clk); tin[0] = 1'b1;
        window(0, 16'd8, "R4 gate high, pin high");
        wr(3, 16'd80);
        window(0, 16'd0, "R4 gate low, pin high");
        @(negedge clk); tin[0] = 1'b0;
        window(0, 16'd8, "R4 gate low, pin low");

        // R9 capture
        wr(3, 16'd73);
        wr(0, 16'h0100);
        wr(1, 16'h0042);
        wr(4, 16'd41);
        pulse(1);
        chk(1, 16'h0100, "R9 capture");
        chk(0, 16'h0100, "R9 core untouched");

        // R10 reload from pin falling edge
        wr(2, 16'h0777);
        wr(5, 16'd34);
        pulse(2);
        chk(0, 16'h0777, "R10 reload");
        chk(2, 16'h0777, "R10 aux holds");

        // R11 PWM with latch-edge reloads (R10 sel bit 2)
        wr(4, 16'd37);
        wr(5, 16'd38);
        wr(1, 16'hFFFC);
        wr(2, 16'hFFFA);
        wr(0, 16'hFFFF);
        wr(3, 16'd64);
        n = 0;
        while (tl_out !== 1'b1 && n < 200) begin @(negedge clk); n++; end
        for (int r = 0; r < 3; r++) begin
            n = 0;
            while (tl_out === 1'b1 && n < 500) begin n++; @(negedge clk); end
            chk_val(n, 32, "R11 high phase");
            n = 0;
            while (tl_out === 1'b0 && n < 500) begin n++; @(negedge clk); end
            chk_val(n, 48, "R11 low phase");
        end

        // R12 concatenation on latch rising transitions
        wr(3, 16'd73);
        wr(5, 16'd0);
        wr(4, 16'd77);
        wr(1, 16'd0);
        tl0 = tl_out;
        for (int k = 0; k < 4; k++) begin
            wr(0, 16'hFFFF);
            pulse(0);
        end
        chk(1, 16'd2, "R12 chained count");

        // R7 auxiliary flag
        wr(6, 16'h0007);
        wr(5, 16'd73);
        wr(2, 16'hFFFF);
        pulse(2);
        chk(2, 16'h0000, "R7 aux B wrap");
        chk(6, {12'b0, tl0, 3'b100}, "R7 aux B flag");
        chk(8, {12'b0, tl0, 3'b100}, "R7 aux irq pin");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule